// File: doc/BRIEF.md
# Two-Channel Wiper Code and Shutdown Controller

This block holds the digital state behind a two-channel, 256-tap resistor ladder. It holds an 8-bit wiper code per channel and two general-purpose logic-output latches. It turns that state into switch controls: a one-hot tap select per channel, a terminal-A disconnect and a wiper-to-B short. A serial front end, which is not part of this block, decodes each transfer into two strobes. The instruction strobe carries a channel select, a midscale-reset bit, a shutdown bit and two logic-output bits. The data strobe carries the new 8-bit code.

Shutdown comes from two sources. An active-low pin forces every channel into shutdown without any clock edge and lets go as soon as it rises. An instruction bit shuts down only the selected channel and stays in force until the next instruction for that channel. In both cases the stored code is kept, and the wiper returns to it when shutdown ends. The logic outputs change only through instructions. They can be wired back to the pin so that the device starts up in shutdown.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset, every channel's code is 0x80, both logic outputs are 0 and no channel is in instruction shutdown.
- R2: A data strobe writes `data_byte` into the channel named by the most recent instruction. `ins_chan` = 0 selects channel 0 and 1 selects channel 1. The other channel's code does not change.
- R3: An instruction with `ins_mid` = 1 sets the selected channel's code to 0x80. Any data strobe that follows it, before the next instruction, is ignored.
- R4: An instruction with `ins_sd` = 1 shuts down the selected channel only. Its `a_open` and `wb_short` bits read 1 and its tap select is tap 0, while the stored code is kept.
- R5: The next instruction for that channel sets its instruction shutdown to that instruction's `ins_sd` bit. When the bit is 0, the tap select returns to the stored code. Instructions for the other channel leave it unchanged.
- R6: While `shdn_n` is 0, every channel reads `a_open` = 1, `wb_short` = 1 and tap 0, with no clock edge needed. All of this clears as soon as the pin rises.
- R7: Each instruction loads `ins_out` into `logic_out` (bit 0 is the first output) and changes no code other than through R3.
- R8: A channel that is not in shutdown drives exactly one tap line, the one at index = code. Code 0x00 selects tap 0 (the B end) and code 0xFF selects tap 255.
- R9: `rd_code` always returns the stored code of the channel named by the most recent instruction, including while that channel is shut down.
- R10: `pin_shdn_stat` equals the inverse of `shdn_n`, delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the power-on state |
| shdn_n | input | 1 | Asynchronous active-low shutdown pin |
| ins_valid | input | 1 | Instruction strobe |
| ins_chan | input | 1 | Channel select of the instruction |
| ins_mid | input | 1 | Midscale reset bit |
| ins_sd | input | 1 | Shutdown bit, active high |
| ins_out | input | 2 | Logic-output values |
| data_valid | input | 1 | Data strobe |
| data_byte | input | 8 | New wiper code |
| tap_sel | output | 512 | One-hot tap select; channel c uses bits [c*256 +: 256] |
| a_open | output | 2 | Terminal-A disconnect, one bit per channel |
| wb_short | output | 2 | Wiper-to-B short, one bit per channel |
| logic_out | output | 2 | Logic-output latches |
| rd_code | output | 8 | Readback of the selected channel's code |
| pin_shdn_stat | output | 1 | Synchronized shutdown-pin status |

## Verification
The assertions check the following on every cycle:
- each channel drives exactly one tap line;
- a low pin forces every channel into shutdown;
- a midscale instruction lands 0x80 in the chosen channel;
- an instruction without midscale leaves both codes unchanged.

Other behaviours can only be shown by the bench's scenarios, against its behavioural model:
- the per-channel scope of the instruction shutdown and when it releases;
- the dropped data byte after a midscale instruction;
- readback during shutdown;
- the pin acting between clock edges;
- the two-edge delay of the pin status.

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int CW  = 8,
  parameter int NCH = 2,
  localparam int SW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shdn_n,
  input  logic                 ins_valid,
  input  logic [SW-1:0]        ins_chan,
  input  logic                 ins_mid,
  input  logic                 ins_sd,
  input  logic [1:0]           ins_out,
  input  logic                 data_valid,
  input  logic [CW-1:0]        data_byte,
  output logic [NCH*TAPS-1:0]  tap_sel,
  output logic [NCH-1:0]       a_open,
  output logic [NCH-1:0]       wb_short,
  output logic [1:0]           logic_out,
  output logic [CW-1:0]        rd_code,
  output logic                 pin_shdn_stat
);
  localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);

  logic [NCH*CW-1:0] code_q;
  logic [NCH-1:0]    soft_sd_q;
  logic [SW-1:0]     sel_q;
  logic              mid_q;
  logic [1:0]        out_q;
  logic [1:0]        sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= {NCH{MID}};
      soft_sd_q <= '0;
      sel_q     <= '0;
      mid_q     <= 1'b0;
      out_q     <= 2'b00;
    end else if (ins_valid) begin
      sel_q               <= ins_chan;
      mid_q               <= ins_mid;
      out_q               <= ins_out;
      soft_sd_q[ins_chan] <= ins_sd;
      if (ins_mid) code_q[ins_chan*CW +: CW] <= MID;
    end else if (data_valid && !mid_q) begin
      code_q[sel_q*CW +: CW] <= data_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], ~shdn_n};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic off;
    assign off                   = soft_sd_q[g] | ~shdn_n;
    assign a_open[g]             = off;
    assign wb_short[g]           = off;
    assign tap_sel[g*TAPS +: TAPS] = off ? TAPS'(1) : (TAPS'(1) << code_q[g*CW +: CW]);
  end

  assign rd_code       = code_q[sel_q*CW +: CW];
  assign logic_out     = out_q;
  assign pin_shdn_stat = sync_q[1];
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int CW  = 8,
  parameter int NCH = 2,
  localparam int SW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << CW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shdn_n,
  input logic                ins_valid,
  input logic [SW-1:0]       ins_chan,
  input logic                ins_mid,
  input logic [NCH*TAPS-1:0] tap_sel,
  input logic [NCH-1:0]      a_open,
  input logic [NCH-1:0]      wb_short,
  input logic [NCH*CW-1:0]   code_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_c
    a_r8_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[g*TAPS +: TAPS]) == 1);
    a_r6_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |-> (a_open[g] && wb_short[g] && tap_sel[g*TAPS]));
  end

  a_r3_mid_loads_center: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_mid) |=> code_q[$past(ins_chan)*CW +: CW] == CW'(1) << (CW - 1));

  a_r7_instr_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_mid) |=> $stable(code_q));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ins_valid(ins_valid),
  .ins_chan(ins_chan), .ins_mid(ins_mid), .tap_sel(tap_sel),
  .a_open(a_open), .wb_short(wb_short), .code_q(code_q)
);

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;
  localparam int TAPS = 256;

  logic clk = 0, rst_n = 0, shdn_n = 1;
  logic ins_valid = 0, ins_chan = 0, ins_mid = 0, ins_sd = 0;
  logic [1:0] ins_out = 0;
  logic data_valid = 0;
  logic [7:0] data_byte = 0;
  logic [2*TAPS-1:0] tap_sel;
  logic [1:0] a_open, wb_short, logic_out;
  logic [7:0] rd_code;
  logic pin_shdn_stat;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_code[2];
  int m_soft[2];
  int m_sel, m_mid, m_out, m_p1, m_p2;

  wiper_ctrl u_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ins_valid(ins_valid),
    .ins_chan(ins_chan), .ins_mid(ins_mid), .ins_sd(ins_sd), .ins_out(ins_out),
    .data_valid(data_valid), .data_byte(data_byte), .tap_sel(tap_sel),
    .a_open(a_open), .wb_short(wb_short), .logic_out(logic_out),
    .rd_code(rd_code), .pin_shdn_stat(pin_shdn_stat)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code[0] = 8'h80; m_code[1] = 8'h80; m_soft[0] = 0; m_soft[1] = 0;
      m_sel = 0; m_mid = 0; m_out = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      if (ins_valid) begin
        m_sel = ins_chan; m_mid = ins_mid; m_out = ins_out;
        m_soft[ins_chan] = ins_sd;
        if (ins_mid) m_code[ins_chan] = 8'h80;
      end else if (data_valid && m_mid == 0) begin
        m_code[m_sel] = data_byte;
      end
      m_p2 = m_p1;
      m_p1 = !shdn_n;
    end
  end

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      int off = (m_soft[c] != 0 || !shdn_n) ? 1 : 0;
      int idx = off ? 0 : m_code[c];
      logic [TAPS-1:0] exp_t = TAPS'(1) << idx;
      chk(tap_sel[c*TAPS +: TAPS] == exp_t, "R8/R4 tap index", tap_sel[c*TAPS +: TAPS] == exp_t, 1);
      chk(a_open[c] == off[0] && wb_short[c] == off[0], "R6/R4 switch state", {a_open[c], wb_short[c]}, {off[0], off[0]});
    end
    chk(logic_out == m_out[1:0], "R7 logic_out", logic_out, m_out);
    chk(rd_code == m_code[m_sel][7:0], "R9 rd_code", rd_code, m_code[m_sel]);
    chk(pin_shdn_stat == m_p2[0], "R10 pin status", pin_shdn_stat, m_p2);
  endtask

  always @(negedge clk) if (rst_n && !done) compare_all();

  task automatic ins(input bit ch, input bit mid, input bit sd, input logic [1:0] o);
    @(negedge clk); #1;
    ins_valid = 1; ins_chan = ch; ins_mid = mid; ins_sd = sd; ins_out = o;
    @(negedge clk); #1;
    ins_valid = 0;
  endtask

  task automatic dat(input logic [7:0] v);
    @(negedge clk); #1;
    data_valid = 1; data_byte = v;
    @(negedge clk); #1;
    data_valid = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr = 32'h1d2c3b4a;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(rd_code == 8'h80, "R1 reset code", rd_code, 8'h80);
    chk(logic_out == 0, "R1 reset logic_out", logic_out, 0);
    chk(a_open == 0, "R1 no shutdown", a_open, 0);

    ins(0, 0, 0, 0); dat(8'h00);
    chk(rd_code == 8'h00 && tap_sel[0], "R2/R8 ch0 code 0x00 tap0", rd_code, 0);
    ins(1, 0, 0, 0); dat(8'hFF);
    chk(tap_sel[TAPS + 255] == 1'b1, "R8 ch1 tap255", tap_sel[TAPS+255], 1);
    ins(0, 0, 0, 0);
    chk(rd_code == 8'h00, "R2 ch0 untouched by ch1 write", rd_code, 0);
    dat(8'h3C);
    ins(1, 1, 0, 0); dat(8'h11);
    chk(rd_code == 8'h80, "R3 midscale and data ignored", rd_code, 8'h80);

    ins(0, 0, 1, 0);
    chk(a_open == 2'b01 && wb_short == 2'b01, "R4 only ch0 shut", a_open, 2'b01);
    chk(rd_code == 8'h3C, "R9 readback in shutdown", rd_code, 8'h3C);
    ins(1, 0, 0, 0);
    chk(a_open[0] == 1'b1, "R5 other-channel instr keeps ch0 shut", a_open[0], 1);
    ins(0, 0, 0, 0);
    chk(a_open[0] == 1'b0 && tap_sel[8'h3C], "R5 ch0 restored to 0x3C", a_open[0], 0);

    ins(1, 0, 0, 2'b10);
    chk(logic_out == 2'b10, "R7 logic_out load", logic_out, 2'b10);
    chk(rd_code == 8'h80, "R7 code unchanged", rd_code, 8'h80);

    @(negedge clk); #1 shdn_n = 0; #0.5;
    chk(a_open == 2'b11 && wb_short == 2'b11, "R6 async pin shutdown", a_open, 2'b11);
    repeat (3) @(negedge clk);
    #1 chk(pin_shdn_stat == 1'b1, "R10 pin status high", pin_shdn_stat, 1);
    shdn_n = 1; #0.5;
    chk(a_open == 2'b00, "R6 pin release", a_open, 0);

    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      case (lfsr[2:0])
        3'd0, 3'd1: ins(lfsr[8], lfsr[9] & lfsr[10], lfsr[11] & lfsr[12], lfsr[14:13]);
        3'd2, 3'd3, 3'd4: dat(lfsr[23:16]);
        3'd5: begin @(negedge clk); #1 shdn_n = lfsr[24] | lfsr[25]; end
        default: @(negedge clk);
      endcase
    end
    shdn_n = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule